// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Logic

This block is the digital core that sits between a motor-control PWM source and the six gate drivers of a three-phase inverter bridge. Each phase receives a high-side and a low-side command. The block debounces every command with a fixed-length glitch filter. It refuses to turn on both switches of a half-bridge together, and it keeps both switches of a phase off for a fixed dead time whenever one of them has just turned off. It then produces one gate-enable bit per switch.

Protection is global. Any of the following removes all six gate enables in the same cycle: an overcurrent trip flag, a low-side supply undervoltage flag, or a low enable input. A trip latches the active-low fault output. When the trip flag drops, a clear-delay timer starts. When the timer expires, the fault output releases and the gates follow their commands again. A per-phase high-side supply undervoltage flag shuts off only that phase's high-side switch. That switch stays off after the flag clears and is armed again only by a fresh active edge on its own command.

Each phase is a four-state machine. The states are PH_OFF, PH_HI, PH_LO and PH_DEAD. Its transitions are:
- OFF→HI and OFF→LO, on a single valid request.
- HI→DEAD and LO→DEAD, when the request is withdrawn, blocked or killed.
- DEAD→HI, DEAD→LO or DEAD→OFF, when the dead counter expires.

The fault controller has three states: FL_OK, FL_TRIP and FL_CLEAR. Its transitions are:
- OK→TRIP, on a trip.
- TRIP→CLEAR, when the trip flag drops.
- CLEAR→TRIP, on a new trip.
- CLEAR→OK, when the delay expires.

Top module: `gate_protect`

## Requirements
- R1: The low-side command pins are active low (0 requests on). The high-side command pins are active low when parameter HS_ACT_HIGH is 0 (default) and active high when it is 1.
- R2: A phase never has both gate enables at 1. When both commands of a phase request on, both gate enables of that phase go to 0.
- R3: Once a gate enable of a phase falls, both enables of that phase stay 0 for exactly DEAD_CYC clock cycles (default 16) before either may rise. A command that swaps sides turns the opposite switch on after exactly that gap.
- R4: When trip_i is 1, all six gate enables are 0 and fault_n_o is 0 in the same cycle.
- R5: After trip_i falls before clock edge E, fault_n_o stays 0 through edge E+CLR_CYC-1 and returns to 1 after edge E+CLR_CYC (CLR_CYC default 1000). Gate enables then follow the commands again.
- R6: A trip that arrives while the clear delay is running restarts the delay, which is counted again in full from the later release of trip_i.
- R7: en_i at 0 forces all six gate enables to 0 in the same cycle and leaves fault_n_o unchanged. When en_i returns to 1, the gates resume after the dead time with no further action.
- R8: uv_ls_i at 1 forces all gate enables to 0 and fault_n_o to 0. fault_n_o returns to 1 in the same cycle that uv_ls_i returns to 0.
- R9: uv_hs_i[p] at 1 turns off high-side gate p by the next clock edge and leaves the other phases untouched. After the flag clears, that gate stays off until a new active edge appears on its high-side command pin.
- R10: A command pin level held for fewer than FILT_CYC consecutive clock samples (default 4) has no effect on the gates, in either polarity. A level held for FILT_CYC samples is accepted.
- R11: During and after reset, all gate enables are 0 and fault_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_cmd_i | input | 3 | High-side commands, one per phase; polarity set by HS_ACT_HIGH |
| ls_cmd_n_i | input | 3 | Low-side commands, one per phase, active low |
| en_i | input | 1 | Gate enable, active high, not latched |
| trip_i | input | 1 | Synchronized overcurrent flag, active high |
| uv_ls_i | input | 1 | Low-side supply undervoltage flag, active high |
| uv_hs_i | input | 3 | Per-phase high-side supply undervoltage flags, active high |
| hs_gate_o | output | 3 | High-side gate enables, one per phase |
| ls_gate_o | output | 3 | Low-side gate enables, one per phase |
| fault_n_o | output | 1 | Fault indication, active low |

## Verification
The bench measures the dead-time gap cycle by cycle in both swap directions. A design that counts one cycle too many or too few, or that lets the opposite side on straight away, gives a gap other than 16.

It checks the clear delay at its exact last-low and first-high cycles, and it re-trips halfway through the delay. An off-by-one counter, or a timer that keeps counting across a re-trip, releases the fault at the wrong cycle.

Command pulses one sample shorter than the filter length are applied in both polarities, and a pulse of exactly the filter length is applied too. These catch a filter that is too eager or too strict. The high-side undervoltage test holds the command active while the flag clears, so a design that re-arms on level instead of on a fresh edge turns the gate back on.

// File: rtl/gdp_pkg.sv
package gdp_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HI   = 2'd1,
        PH_LO   = 2'd2,
        PH_DEAD = 2'd3
    } ph_state_t;

    typedef enum logic [1:0] {
        FL_OK    = 2'd0,
        FL_TRIP  = 2'd1,
        FL_CLEAR = 2'd2
    } fl_state_t;
endpackage

// File: rtl/gdp_glitch_filter.sv
module gdp_glitch_filter #(
    parameter int FILT_CYC = 4,
    parameter bit RST_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CLAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_o  <= RST_LVL;
            run_cnt <= '0;
        end else if (raw_i == filt_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CLAST) begin
            filt_o  <= raw_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R10: a differing level not yet held long enough leaves the output alone
    assert_glitch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i != filt_o && run_cnt != CLAST) |=> $stable(filt_o));
endmodule

// File: rtl/gdp_phase.sv
module gdp_phase
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req_i,
    input  logic ls_req_i,
    input  logic uv_hs_i,
    input  logic kill_i,
    output logic hs_on_o,
    output logic ls_on_o
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DLAST = DW'(DEAD_CYC - 1);

    ph_state_t     st, st_nxt;
    logic [DW-1:0] dcnt, dcnt_nxt;
    logic          hs_req_d, hs_armed, arm_ok;
    logic          want_h, want_l;

    // high-side arming: cleared by undervoltage or reset, set by a fresh request edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_req_d <= 1'b0;
            hs_armed <= 1'b0;
        end else begin
            hs_req_d <= hs_req_i;
            if (uv_hs_i)
                hs_armed <= 1'b0;
            else if (hs_req_i && !hs_req_d)
                hs_armed <= 1'b1;
        end
    end

    assign arm_ok = hs_armed | (hs_req_i & ~hs_req_d);
    assign want_h = hs_req_i & arm_ok & ~uv_hs_i & ~ls_req_i & ~kill_i;
    assign want_l = ls_req_i & ~hs_req_i & ~kill_i;

    always_comb begin
        st_nxt   = st;
        dcnt_nxt = dcnt;
        unique case (st)
            PH_OFF: begin
                if (want_h)      st_nxt = PH_HI;
                else if (want_l) st_nxt = PH_LO;
            end
            PH_HI: begin
                if (!want_h) begin
                    st_nxt   = PH_DEAD;
                    dcnt_nxt = '0;
                end
            end
            PH_LO: begin
                if (!want_l) begin
                    st_nxt   = PH_DEAD;
                    dcnt_nxt = '0;
                end
            end
            PH_DEAD: begin
                if (dcnt == DLAST) begin
                    dcnt_nxt = '0;
                    if (want_h)      st_nxt = PH_HI;
                    else if (want_l) st_nxt = PH_LO;
                    else             st_nxt = PH_OFF;
                end else begin
                    dcnt_nxt = dcnt + 1'b1;
                end
            end
            default: st_nxt = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= PH_OFF;
            dcnt <= '0;
        end else begin
            st   <= st_nxt;
            dcnt <= dcnt_nxt;
        end
    end

    always_comb begin
        hs_on_o = (st == PH_HI) & ~kill_i;
        ls_on_o = (st == PH_LO) & ~kill_i;
    end

    assert_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));
    assert_both_req_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req_i && ls_req_i) |=> (!hs_on_o && !ls_on_o));
    assert_dead_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_DEAD && dcnt != DLAST) |=> (!hs_on_o && !ls_on_o));
    assert_hs_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_hs_i |=> !hs_on_o);
endmodule

// File: rtl/gdp_fault_ctrl.sv
module gdp_fault_ctrl
    import gdp_pkg::*;
#(
    parameter int CLR_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic uv_ls_i,
    output logic fault_o
);
    localparam int CW = $clog2(CLR_CYC + 1);
    localparam logic [CW-1:0] CLAST = CW'(CLR_CYC - 1);

    fl_state_t     st, st_nxt;
    logic [CW-1:0] ccnt, ccnt_nxt;

    always_comb begin
        st_nxt   = st;
        ccnt_nxt = ccnt;
        unique case (st)
            FL_OK:    if (trip_i) st_nxt = FL_TRIP;
            FL_TRIP: begin
                if (!trip_i) begin
                    st_nxt   = FL_CLEAR;
                    ccnt_nxt = '0;
                end
            end
            FL_CLEAR: begin
                if (trip_i) begin
                    st_nxt   = FL_TRIP;
                    ccnt_nxt = '0;
                end else if (ccnt == CLAST) begin
                    st_nxt   = FL_OK;
                    ccnt_nxt = '0;
                end else begin
                    ccnt_nxt = ccnt + 1'b1;
                end
            end
            default: st_nxt = FL_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= FL_OK;
            ccnt <= '0;
        end else begin
            st   <= st_nxt;
            ccnt <= ccnt_nxt;
        end
    end

    always_comb begin
        fault_o = (st != FL_OK) | trip_i | uv_ls_i;
    end

    assert_clear_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FL_CLEAR && ccnt != CLAST) |=> fault_o);
    assert_retrip_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FL_CLEAR && trip_i) |=> (st == FL_TRIP && ccnt == '0));
endmodule

// File: rtl/gate_protect.sv
module gate_protect
    import gdp_pkg::*;
#(
    parameter int NPH         = 3,
    parameter int FILT_CYC    = 4,
    parameter int DEAD_CYC    = 16,
    parameter int CLR_CYC     = 1000,
    parameter bit HS_ACT_HIGH = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hs_cmd_i,
    input  logic [NPH-1:0] ls_cmd_n_i,
    input  logic           en_i,
    input  logic           trip_i,
    input  logic           uv_ls_i,
    input  logic [NPH-1:0] uv_hs_i,
    output logic [NPH-1:0] hs_gate_o,
    output logic [NPH-1:0] ls_gate_o,
    output logic           fault_n_o
);
    localparam bit HS_IDLE = ~HS_ACT_HIGH;

    logic [NPH-1:0] hs_q, ls_q, hs_req, ls_req;
    logic           fault_act, kill;

    gdp_fault_ctrl #(.CLR_CYC(CLR_CYC)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_i  (trip_i),
        .uv_ls_i (uv_ls_i),
        .fault_o (fault_act)
    );

    assign kill      = ~en_i | fault_act;
    assign fault_n_o = ~fault_act;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        gdp_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(HS_IDLE)) u_hs_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (hs_cmd_i[p]),
            .filt_o (hs_q[p])
        );
        gdp_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_LVL(1'b1)) u_ls_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (ls_cmd_n_i[p]),
            .filt_o (ls_q[p])
        );

        assign hs_req[p] = HS_ACT_HIGH ? hs_q[p] : ~hs_q[p];
        assign ls_req[p] = ~ls_q[p];

        gdp_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .hs_req_i (hs_req[p]),
            .ls_req_i (ls_req[p]),
            .uv_hs_i  (uv_hs_i[p]),
            .kill_i   (kill),
            .hs_on_o  (hs_gate_o[p]),
            .ls_on_o  (ls_gate_o[p])
        );
    end

    assert_trip_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |-> (hs_gate_o == '0 && ls_gate_o == '0 && !fault_n_o));
    assert_en_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (hs_gate_o == '0 && ls_gate_o == '0));
    assert_uvls_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_ls_i |-> (hs_gate_o == '0 && ls_gate_o == '0 && !fault_n_o));
    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |-> (hs_gate_o == '0 && ls_gate_o == '0 && fault_n_o));
endmodule

// File: tb/gate_protect_bench.sv
`timescale 1ns/1ps
module gate_protect_bench;
    localparam int FILT = 4;
    localparam int DEAD = 16;
    localparam int CLR  = 1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hin, lin, uvh;
    logic       en, trip, uvl;
    logic [2:0] ho, lo;
    logic       fault_n;

    logic [2:0] hin_ah, lin_ah, ho_ah, lo_ah;
    logic       fault_n_ah;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gate_protect u_gate_protect (
        .clk(clk), .rst_n(rst_n), .hs_cmd_i(hin), .ls_cmd_n_i(lin), .en_i(en),
        .trip_i(trip), .uv_ls_i(uvl), .uv_hs_i(uvh),
        .hs_gate_o(ho), .ls_gate_o(lo), .fault_n_o(fault_n)
    );

    gate_protect #(.HS_ACT_HIGH(1'b1)) u_gate_protect_ah (
        .clk(clk), .rst_n(rst_n), .hs_cmd_i(hin_ah), .ls_cmd_n_i(lin_ah), .en_i(1'b1),
        .trip_i(1'b0), .uv_ls_i(1'b0), .uv_hs_i(3'b000),
        .hs_gate_o(ho_ah), .ls_gate_o(lo_ah), .fault_n_o(fault_n_ah)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic t_reset();
        chk("R11 gates in reset", int'({ho, lo}), 0);
        chk("R11 fault in reset", int'(fault_n), 1);
        rst_n = 1'b1;
        step(3);
        chk("R11 gates after reset", int'({ho, lo}), 0);
        chk("R11 fault after reset", int'(fault_n), 1);
    endtask

    task automatic t_ls_polarity();
        lin[0] = 1'b0;
        step(8);
        chk("R1 low-side on when pin low", int'(lo[0]), 1);
        chk("R1 high-side stays off", int'(ho[0]), 0);
        lin[0] = 1'b1;
        step(8);
        chk("R1 low-side off when pin high", int'(lo[0]), 0);
        step(DEAD + 4);
    endtask

    task automatic t_filter();
        int seen;
        seen = 0;
        lin[1] = 1'b0;
        step(FILT - 1);
        lin[1] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (lo[1]) seen = 1;
        end
        chk("R10 short on-pulse ignored", seen, 0);
        hin[1] = 1'b0;
        step(30);
        chk("R10 high-side on for glitch test", int'(ho[1]), 1);
        seen = 0;
        hin[1] = 1'b1;
        step(FILT - 1);
        hin[1] = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (!ho[1]) seen = 1;
        end
        chk("R10 short off-glitch ignored", seen, 0);
        hin[1] = 1'b1;
        step(DEAD + 10);
        seen = 0;
        lin[2] = 1'b0;
        step(FILT);
        lin[2] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (lo[2]) seen = 1;
        end
        chk("R10 full-length pulse accepted", seen, 1);
        step(DEAD + 4);
    endtask

    task automatic t_dead();
        int gap;
        hin[0] = 1'b0;
        step(30);
        chk("R3 high-side on before swap", int'(ho[0]), 1);
        hin[0] = 1'b1;
        lin[0] = 1'b0;
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (lo[0]) break;
            if (!ho[0] && !lo[0]) gap++;
        end
        chk("R3 dead gap high to low", gap, DEAD);
        step(30);
        lin[0] = 1'b1;
        hin[0] = 1'b0;
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (ho[0]) break;
            if (!ho[0] && !lo[0]) gap++;
        end
        chk("R3 dead gap low to high", gap, DEAD);
        step(5);
    endtask

    task automatic t_both();
        int bad;
        bad = 0;
        lin[0] = 1'b0;
        step(10);
        chk("R2 both requested: high off", int'(ho[0]), 0);
        chk("R2 both requested: low off", int'(lo[0]), 0);
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (ho[0] && lo[0]) bad = 1;
        end
        chk("R2 never both on", bad, 0);
        lin[0] = 1'b1;
        step(DEAD + 10);
        chk("R2 high returns after conflict", int'(ho[0]), 1);
    endtask

    task automatic t_enable();
        en = 1'b0;
        #1;
        chk("R7 gates off same cycle", int'({ho, lo}), 0);
        chk("R7 fault unaffected", int'(fault_n), 1);
        step(5);
        chk("R7 gates held off", int'({ho, lo}), 0);
        en = 1'b1;
        step(DEAD + 10);
        chk("R7 gates resume after enable", int'(ho[0]), 1);
    endtask

    task automatic t_uv_ls();
        uvl = 1'b1;
        #1;
        chk("R8 gates off on low-side uv", int'({ho, lo}), 0);
        chk("R8 fault asserted", int'(fault_n), 0);
        step(5);
        uvl = 1'b0;
        #1;
        chk("R8 fault releases at once", int'(fault_n), 1);
        step(DEAD + 10);
        chk("R8 gates resume", int'(ho[0]), 1);
    endtask

    task automatic t_trip();
        trip = 1'b1;
        #1;
        chk("R4 gates off on trip", int'({ho, lo}), 0);
        chk("R4 fault on trip", int'(fault_n), 0);
        step(5);
        trip = 1'b0;
        step(CLR);
        chk("R5 fault still low at last delay cycle", int'(fault_n), 0);
        chk("R5 gates off during delay", int'({ho, lo}), 0);
        step(1);
        chk("R5 fault released after delay", int'(fault_n), 1);
        step(2);
        chk("R5 gates follow again", int'(ho[0]), 1);
    endtask

    task automatic t_retrip();
        trip = 1'b1;
        step(2);
        trip = 1'b0;
        step(500);
        trip = 1'b1;
        step(1);
        trip = 1'b0;
        step(CLR);
        chk("R6 delay restarted by new trip", int'(fault_n), 0);
        step(1);
        chk("R6 release after full restarted delay", int'(fault_n), 1);
        step(DEAD + 4);
    endtask

    task automatic t_uv_hs();
        hin[1] = 1'b0;
        step(30);
        chk("R9 both high sides on", int'(ho[1:0]), 3);
        uvh = 3'b001;
        step(1);
        chk("R9 phase 0 high off on uv", int'(ho[0]), 0);
        chk("R9 phase 1 untouched", int'(ho[1]), 1);
        step(5);
        uvh = 3'b000;
        step(40);
        chk("R9 stays off without fresh edge", int'(ho[0]), 0);
        hin[0] = 1'b1;
        step(10);
        hin[0] = 1'b0;
        step(30);
        chk("R9 fresh edge re-arms", int'(ho[0]), 1);
    endtask

    task automatic t_active_high();
        hin_ah[0] = 1'b1;
        step(10);
        chk("R1 active-high mode turns on", int'(ho_ah[0]), 1);
        hin_ah[0] = 1'b0;
        step(10);
        chk("R1 active-high mode turns off", int'(ho_ah[0]), 0);
    endtask

    initial begin
        rst_n  = 1'b0;
        hin    = 3'b111;
        lin    = 3'b111;
        uvh    = 3'b000;
        en     = 1'b1;
        trip   = 1'b0;
        uvl    = 1'b0;
        hin_ah = 3'b000;
        lin_ah = 3'b111;
        step(3);
        t_reset();
        t_ls_polarity();
        t_filter();
        t_dead();
        t_both();
        t_enable();
        t_uv_ls();
        t_trip();
        t_retrip();
        t_uv_hs();
        t_active_high();
        finish_run();
    end
endmodule